// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 pointer image over a stream of display pixels. Software loads two bit planes and a position through a small 32-bit register port. One plane is a visibility mask and the other selects between two overlay colours. The overlay colours come from an external palette. Each incoming pixel carries its own x and y coordinates. The block forwards that pixel one clock later, either unchanged or replaced by one of the two overlay colours.

The cursor image occupies 32 lines starting at the programmed y position and 32 columns starting at the programmed x position. Each row is stored as a 32-bit word. Its most significant bit belongs to the leftmost cursor column. The live display width and height arrive on input ports. Pixels on or beyond the right edge, and lines on or beyond the bottom edge, are never overlaid. The block also keeps one general-purpose register, which reads back with a fixed flag bit forced on.

Top module: `cursor_overlay`

## Requirements
- R1: A write to byte offset 0x8FC loads cursor x from write data bits 31:16 and cursor y from bits 15:0. A pixel presented in the same cycle as the write still uses the old position. Pixels in later cycles use the new one.
- R2: A write to offset 0x900 + 4*r (r = 0..31) loads mask row r. A write to offset 0x980 + 4*r loads colour-select row r.
- R3: Overlay is applied only on lines y with cursor_y <= y <= cursor_y + 31 and y < display height. Row r = y - cursor_y is the row used.
- R4: On a cursor line, column x = cursor_x + k (k = 0..31) uses bit 31-k of the row words. Nothing is overlaid at x >= display width. Nothing is overlaid at all when cursor_x >= display width.
- R5: Where the mask bit is 1, the output colour is `ovl_col1` if the colour-select bit is 1 and `ovl_col0` if it is 0. Where the mask bit is 0, the input colour passes through.
- R6: After reset the cursor position is x = y = 0xF000, all rows are zero, the general register is zero and `out_vld` is low, so every pixel passes unchanged.
- R7: `reg_rdata` follows `reg_addr` combinationally. At offset 0x818 it returns the stored general register ORed with 0x02000000. At every other offset it returns zero. A write to 0x818 stores the full 32-bit word.
- R8: `out_vld`, `out_x`, `out_y` and `out_col` appear exactly one clock after the matching pixel inputs. `out_vld` is low in a cycle after a cycle with no input pixel.
- R9: Pixels outside the 32x32 window pass through unchanged. This covers the column just before cursor_x, the column cursor_x+32, and the lines just above and just below the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| disp_w | input | 16 | Active display width in pixels |
| disp_h | input | 16 | Active display height in lines |
| ovl_col0 | input | COL_W | Overlay colour when colour-select bit is 0 |
| ovl_col1 | input | COL_W | Overlay colour when colour-select bit is 1 |
| pix_vld | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel line |
| pix_col | input | COL_W | Input pixel colour |
| out_vld | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel line |
| out_col | output | COL_W | Output pixel colour |

## Verification
The assertions check the following on every cycle:
- The one-cycle alignment of valid, coordinates and colour.
- That an output colour is always the input colour or one of the two overlay colours.
- That pixels right of the display width or below the display height pass untouched.
- The read-back rules for the general register and for every other offset.

Some behaviour is only shown by the bench scenarios, which compare each cycle against a behavioural model:
- That the correct bit, MSB first, is picked for each column.
- That the row index follows the line offset.
- That a position write does not affect a pixel in its own cycle.
- That clipping at the right edge works with the cursor straddling it.

// File: rtl/curs_pkg.sv
package curs_pkg;
    localparam int CRD_W  = 16;
    localparam int ROWS   = 32;
    localparam int ROW_W  = 32;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int RIDX_W = $clog2(ROWS);
    localparam int CIDX_W = $clog2(ROW_W);

    localparam logic [ADDR_W-1:0] OFS_GEN  = 12'h818;
    localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h900;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 12'h980;
    localparam logic [ADDR_W-1:0] PLANE_SPAN = ADDR_W'(ROWS * 4);

    localparam logic [DATA_W-1:0] GEN_FLAG = 32'h0200_0000;
    localparam logic [CRD_W-1:0]  POS_PARK = 16'hF000;

    typedef struct packed {
        logic [CRD_W-1:0]             cx;
        logic [CRD_W-1:0]             cy;
        logic [DATA_W-1:0]            gen;
        logic [ROWS-1:0][ROW_W-1:0]   mask;
        logic [ROWS-1:0][ROW_W-1:0]   sel;
    } curs_state_t;
endpackage

// File: rtl/curs_regs.sv
module curs_regs
    import curs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output curs_state_t       state
);
    curs_state_t st_d, st_q;

    logic [ADDR_W-1:0] mask_off, sel_off;
    logic              in_mask, in_sel;
    logic [RIDX_W-1:0] mask_row, sel_row;
    logic [ROWS-1:0]   mask_we, sel_we;

    assign mask_off = addr - OFS_MASK;
    assign sel_off  = addr - OFS_SEL;
    assign in_mask  = (addr >= OFS_MASK) && (mask_off < PLANE_SPAN);
    assign in_sel   = (addr >= OFS_SEL) && (sel_off < PLANE_SPAN);
    assign mask_row = mask_off[RIDX_W+1:2];
    assign sel_row  = sel_off[RIDX_W+1:2];

    for (genvar g = 0; g < ROWS; g++) begin : g_row_we
        assign mask_we[g] = wr_en && in_mask && (mask_row == RIDX_W'(g));
        assign sel_we[g]  = wr_en && in_sel  && (sel_row  == RIDX_W'(g));
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == OFS_POS) begin
            st_d.cx = wdata[31:16];
            st_d.cy = wdata[15:0];
        end
        if (wr_en && addr == OFS_GEN) begin
            st_d.gen = wdata;
        end
        for (int r = 0; r < ROWS; r++) begin
            if (mask_we[r]) st_d.mask[r] = wdata[ROW_W-1:0];
            if (sel_we[r])  st_d.sel[r]  = wdata[ROW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cx   <= POS_PARK;
            st_q.cy   <= POS_PARK;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = (addr == OFS_GEN) ? (st_q.gen | GEN_FLAG) : '0;
    assign state = st_q;
endmodule

// File: rtl/curs_mix.sv
module curs_mix
    import curs_pkg::*;
#(
    parameter int COL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  curs_state_t      state,
    input  logic [CRD_W-1:0] disp_w,
    input  logic [CRD_W-1:0] disp_h,
    input  logic [COL_W-1:0] ovl_col0,
    input  logic [COL_W-1:0] ovl_col1,
    input  logic             pix_vld,
    input  logic [CRD_W-1:0] pix_x,
    input  logic [CRD_W-1:0] pix_y,
    input  logic [COL_W-1:0] pix_col,
    output logic             out_vld,
    output logic [CRD_W-1:0] out_x,
    output logic [CRD_W-1:0] out_y,
    output logic [COL_W-1:0] out_col
);
    localparam logic [CRD_W-1:0]  ROWS_C = CRD_W'(ROWS);
    localparam logic [CRD_W-1:0]  COLS_C = CRD_W'(ROW_W);
    localparam logic [CIDX_W-1:0] LAST_B = CIDX_W'(ROW_W - 1);

    typedef struct packed {
        logic             vld;
        logic [CRD_W-1:0] x;
        logic [CRD_W-1:0] y;
        logic [COL_W-1:0] col;
    } pix_t;

    pix_t px_d, px_q;

    logic [CRD_W:0]    dy, dx;
    logic              y_in, x_in;
    logic [RIDX_W-1:0] row_idx;
    logic [CIDX_W-1:0] bit_idx;
    logic              m_bit, s_bit;

    always_comb begin
        dy      = {1'b0, pix_y} - {1'b0, state.cy};
        dx      = {1'b0, pix_x} - {1'b0, state.cx};
        y_in    = !dy[CRD_W] && (dy[CRD_W-1:0] < ROWS_C) && (pix_y < disp_h);
        x_in    = !dx[CRD_W] && (dx[CRD_W-1:0] < COLS_C) && (pix_x < disp_w)
                  && (state.cx < disp_w);
        row_idx = dy[RIDX_W-1:0];
        bit_idx = LAST_B - dx[CIDX_W-1:0];
        m_bit   = state.mask[row_idx][bit_idx];
        s_bit   = state.sel[row_idx][bit_idx];

        px_d.vld = pix_vld;
        px_d.x   = pix_x;
        px_d.y   = pix_y;
        px_d.col = pix_col;
        if (y_in && x_in && m_bit) begin
            px_d.col = s_bit ? ovl_col1 : ovl_col0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) px_q <= '0;
        else        px_q <= px_d;
    end

    assign out_vld = px_q.vld;
    assign out_x   = px_q.x;
    assign out_y   = px_q.y;
    assign out_col = px_q.col;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import curs_pkg::*;
#(
    parameter int COL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CRD_W-1:0]  disp_w,
    input  logic [CRD_W-1:0]  disp_h,
    input  logic [COL_W-1:0]  ovl_col0,
    input  logic [COL_W-1:0]  ovl_col1,
    input  logic              pix_vld,
    input  logic [CRD_W-1:0]  pix_x,
    input  logic [CRD_W-1:0]  pix_y,
    input  logic [COL_W-1:0]  pix_col,
    output logic              out_vld,
    output logic [CRD_W-1:0]  out_x,
    output logic [CRD_W-1:0]  out_y,
    output logic [COL_W-1:0]  out_col
);
    curs_state_t state;

    curs_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .state (state)
    );

    curs_mix #(.COL_W(COL_W)) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .disp_w   (disp_w),
        .disp_h   (disp_h),
        .ovl_col0 (ovl_col0),
        .ovl_col1 (ovl_col1),
        .pix_vld  (pix_vld),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .pix_col  (pix_col),
        .out_vld  (out_vld),
        .out_x    (out_x),
        .out_y    (out_y),
        .out_col  (out_col)
    );
endmodule

// File: rtl/curs_chk.sv
module curs_chk
    import curs_pkg::*;
#(
    parameter int COL_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [CRD_W-1:0]  disp_w,
    input logic [CRD_W-1:0]  disp_h,
    input logic [COL_W-1:0]  ovl_col0,
    input logic [COL_W-1:0]  ovl_col1,
    input logic              pix_vld,
    input logic [CRD_W-1:0]  pix_x,
    input logic [CRD_W-1:0]  pix_y,
    input logic [COL_W-1:0]  pix_col,
    input logic              out_vld,
    input logic [CRD_W-1:0]  out_x,
    input logic [CRD_W-1:0]  out_y,
    input logic [COL_W-1:0]  out_col
);
    assert_lat_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> !out_vld);

    assert_lat_xy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> (out_x == $past(pix_x) && out_y == $past(pix_y)));

    assert_clip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_x >= disp_w) |=> (out_col == $past(pix_col)));

    assert_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_y >= disp_h) |=> (out_col == $past(pix_col)));

    assert_col_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> (out_col == $past(pix_col) || out_col == $past(ovl_col0)
                     || out_col == $past(ovl_col1)));

    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_GEN) |-> (reg_rdata == '0));

    assert_rd_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_GEN) |-> reg_rdata[25]);
endmodule

bind cursor_overlay curs_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/cursor_overlay_tb_top.sv
`timescale 1ns/1ps
module cursor_overlay_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] disp_w, disp_h;
    logic [23:0] ovl_col0, ovl_col1;
    logic        pix_vld;
    logic [15:0] pix_x, pix_y;
    logic [23:0] pix_col;
    logic        out_vld;
    logic [15:0] out_x, out_y;
    logic [23:0] out_col;

    always #2 clk = ~clk;

    cursor_overlay #(.COL_W(24)) dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_mask [32];
    logic [31:0] m_sel  [32];
    int          m_cx, m_cy;
    logic [31:0] m_gen;

    logic        e_vld = 0;
    logic [15:0] e_x = 0, e_y = 0;
    logic [23:0] e_col = 0;
    string       e_tag = "R6";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_col(input int x, input int y, input logic [23:0] c);
        int r, k;
        if (y >= m_cy && y - m_cy < 32 && y < int'(disp_h) &&
            m_cx < int'(disp_w) && x >= m_cx && x - m_cx < 32 && x < int'(disp_w)) begin
            r = y - m_cy;
            k = x - m_cx;
            if (m_mask[r][31-k]) return m_sel[r][31-k] ? ovl_col1 : ovl_col0;
        end
        return c;
    endfunction

    task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit v, input int x, input int y, input logic [23:0] c,
                        input string tag);
        logic [31:0] e_rd;
        @(negedge clk);
        chk(out_vld == e_vld, e_tag, "out_vld", out_vld, e_vld);
        if (e_vld) begin
            chk(out_x == e_x, e_tag, "out_x", out_x, e_x);
            chk(out_y == e_y, e_tag, "out_y", out_y, e_y);
            chk(out_col == e_col, e_tag, "out_col", out_col, e_col);
        end
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        pix_vld = v; pix_x = 16'(x); pix_y = 16'(y); pix_col = c;
        #1;
        e_rd = (a == 12'h818) ? (m_gen | 32'h0200_0000) : 32'h0;
        chk(reg_rdata == e_rd, "R7", "reg_rdata", reg_rdata, e_rd);
        e_vld = v; e_x = 16'(x); e_y = 16'(y);
        e_col = ref_col(x, y, c); e_tag = tag;
        if (wr) begin
            if (a == 12'h8FC) begin m_cx = int'(d[31:16]); m_cy = int'(d[15:0]); end
            if (a == 12'h818) m_gen = d;
            if (a >= 12'h900 && a < 12'h980) m_mask[(a - 12'h900) >> 2] = d;
            if (a >= 12'h980 && a < 12'hA00) m_sel[(a - 12'h980) >> 2] = d;
        end
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1, a, d, 0, 0, 0, 24'h0, tag);
    endtask

    task automatic pix(input int x, input int y, input string tag);
        step(0, 12'h000, 32'h0, 1, x, y, 24'h100000 + 24'(x) + 24'(y << 12), tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(0, a, 32'h0, 0, 0, 0, 24'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_sel[i] = '0; end
        m_cx = 16'hF000; m_cy = 16'hF000; m_gen = '0;
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        pix_vld = 0; pix_x = 0; pix_y = 0; pix_col = 0;
        disp_w = 16'd640; disp_h = 16'd480;
        ovl_col0 = 24'hA0A0A0; ovl_col1 = 24'h5F5F5F;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R6: reset state, parked cursor, flag-only readback
        rd(12'h818, "R6");
        pix(0, 0, "R6");
        pix(639, 479, "R6");
        rd(12'h000, "R8");

        // R7: general register
        wreg(12'h818, 32'h0000_0055, "R7");
        rd(12'h818, "R7");
        rd(12'h81C, "R7");
        rd(12'h900, "R7");

        // R2: plane rows
        wreg(12'h900, 32'h8000_0001, "R2");
        wreg(12'h980, 32'h8000_0000, "R2");
        wreg(12'h914, 32'hFFFF_FFFF, "R2");
        wreg(12'h994, 32'hAAAA_AAAA, "R2");
        wreg(12'h904, 32'hFFFF_FFFF, "R2");
        wreg(12'h97C, 32'hF000_0000, "R2");
        wreg(12'h9FC, 32'h3000_0000, "R2");

        // R1: position write; same-cycle pixel uses old position
        step(1, 12'h8FC, {16'd100, 16'd50}, 1, 100, 50, 24'h123456, "R1");
        pix(100, 50, "R1");

        // R4 / R5 / R9: row 0 scan incl. neighbours
        for (int x = 98; x <= 134; x++) pix(x, 50, "R4");
        // R5: row 5 alternating colour select
        for (int x = 99; x <= 133; x++) pix(x, 55, "R5");
        // R3: last row and line after window, line before
        for (int x = 99; x <= 105; x++) pix(x, 81, "R3");
        for (int x = 99; x <= 105; x++) pix(x, 82, "R9");
        for (int x = 99; x <= 105; x++) pix(x, 49, "R9");

        // R4: straddle right edge
        wreg(12'h8FC, {16'd625, 16'd10}, "R1");
        for (int x = 622; x <= 660; x++) pix(x, 15, "R4");
        // R4: cursor x at width, nothing drawn
        wreg(12'h8FC, {16'd640, 16'd10}, "R1");
        for (int x = 636; x <= 643; x++) pix(x, 15, "R4");
        wreg(12'h8FC, {16'd0, 16'd10}, "R1");
        for (int x = 0; x <= 33; x++) pix(x, 15, "R4");

        // R3: bottom clipping
        wreg(12'h8FC, {16'd200, 16'd478}, "R1");
        for (int x = 199; x <= 203; x++) pix(x, 478, "R3");
        for (int x = 199; x <= 203; x++) pix(x, 479, "R3");
        for (int x = 199; x <= 203; x++) pix(x, 480, "R3");
        for (int x = 199; x <= 203; x++) pix(x, 483, "R3");

        // R8: gaps between pixels
        wreg(12'h8FC, {16'd100, 16'd50}, "R1");
        pix(100, 50, "R8");
        rd(12'h000, "R8");
        pix(131, 50, "R8");
        rd(12'h000, "R8");
        rd(12'h000, "R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule